// File: doc/BRIEF.md
# Fixed-Peripheral-Address DMA Channel

This block is a single DMA channel that copies one byte or one 16-bit word per accepted transfer request. The copy runs between a 24-bit memory-side address and a fixed peripheral-side address. The channel is programmed through a small register write port while it is idle, and is then enabled. From that point every request moves one unit, until the programmed transfer count is used up. At that moment the channel switches itself off and emits a one-cycle completion pulse.

The memory-side address steps after every unit, by one for bytes or by two for words, upward or downward as programmed. The peripheral-side address is built from an 8-bit register with sixteen one-bits placed above it, and it never moves. The direction is not programmed: it follows from the source tag carried by each request. The serial-receive source (code 0) copies from the peripheral into memory, and every other source copies from memory to the peripheral. Each unit takes one read bus cycle followed by one write bus cycle, with the data held in an internal buffer in between. Requests that arrive while a unit is in flight wait in a small queue.

Top module: `dma_fixed_chan`

## Requirements
- R1: After reset, `chan_on`, `bus_req` and `done` are all 0.
- R2: A register write (`cfg_we`=1) is taken only while `chan_on`=0. `cfg_sel` selects the target: 0 is the memory address (`cfg_wdata[23:0]`), 1 is the peripheral address byte (`cfg_wdata[7:0]`), 2 is the transfer count (`cfg_wdata[15:0]`), and 3 is control. In control, bit 0 enables the channel, bit 1 selects word units (0 selects bytes) and bit 2 selects a downward step. While `chan_on`=1, writes to any target have no effect.
- R3: A control write that sets the enable bit while the transfer count is zero leaves `chan_on` at 0.
- R4: Every peripheral-side bus access uses address `{16'hFFFF, periph_byte}`, and that address is the same for every unit of a run.
- R5: A request with `req_src`=0 reads from the peripheral address and writes to the memory address. Any other `req_src` value reads from the memory address and writes to the peripheral address.
- R6: Each unit is one read cycle (`bus_req`=1, `bus_we`=0) immediately followed by one write cycle (`bus_req`=1, `bus_we`=1). The write data equals the `bus_rdata` value sampled in the read cycle.
- R7: After each unit, the memory address moves by 1 (bytes) or 2 (words), up or down, modulo 2^24. `bus_word` shows the unit size during both bus cycles.
- R8: The count drops by one per unit. The clock edge that ends the write of the last unit sets `done`=1 for exactly one cycle and sets `chan_on`=0 in that same cycle.
- R9: Requests presented while `chan_on`=0 cause no bus cycle, both before enabling and after completion.
- R10: A request sampled at a clock edge puts its read cycle on the bus two edges later when the channel is idle. Requests that arrive while a unit is in flight are queued (up to `PEND_DEPTH`) and served in arrival order, one unit at a time, each with its own direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 memory address, 1 peripheral byte, 2 count, 3 control) |
| cfg_wdata | input | 24 | Register write data |
| req_valid | input | 1 | Transfer request, one per cycle |
| req_src | input | 2 | Source tag of the request; 0 is the serial-receive source |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | 24 | Bus address |
| bus_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of a read cycle |
| chan_on | output | 1 | Channel enabled |
| done | output | 1 | One-cycle pulse when the count runs out |

## Verification
A wrong memory address or step shows up on `bus_addr` in the very next unit, in the read or write cycle according to direction. The bench compares every unit's addresses, so a drift is caught within one transfer. A wrong count shows up as a `done` pulse and a drop of `chan_on` that comes one unit early or late. A lost or reordered queued request shows up as a swapped direction, or as a missing unit in the back-to-back run, within three cycles of where it was expected. A configuration write that leaks through while the channel is enabled changes the addresses of the following unit.

// File: rtl/dma_fixed_pkg.sv
package dma_fixed_pkg;
  localparam int ADDR_W = 24;
  localparam int PBYTE_W = 8;
  localparam int CNT_W = 16;
  localparam int DATA_W = 16;
  localparam int SRC_W = 2;

  typedef enum logic [1:0] {
    SEL_MEM   = 2'd0,
    SEL_PBYTE = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  // Next memory-side address after one unit.
  function automatic logic [ADDR_W-1:0] mem_advance(
    input logic [ADDR_W-1:0] addr,
    input logic              word,
    input logic              down
  );
    logic [ADDR_W-1:0] delta;
    delta = word ? ADDR_W'(2) : ADDR_W'(1);
    return down ? (addr - delta) : (addr + delta);
  endfunction

  // Full peripheral-side address: ones above the programmed byte.
  function automatic logic [ADDR_W-1:0] periph_full(input logic [PBYTE_W-1:0] pbyte);
    return {{(ADDR_W-PBYTE_W){1'b1}}, pbyte};
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_fixed_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               step,
  input  logic               finish,
  output logic [ADDR_W-1:0]  mem_q,
  output logic [PBYTE_W-1:0] pbyte_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               word_q,
  output logic               down_q,
  output logic               en_q
);
  logic wr_ok;
  assign wr_ok = cfg_we && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q   <= '0;
      pbyte_q <= '0;
      cnt_q   <= '0;
      word_q  <= 1'b0;
      down_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (finish) en_q <= 1'b0;
      if (step) begin
        mem_q <= mem_advance(mem_q, word_q, down_q);
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (wr_ok) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_MEM:   mem_q   <= cfg_wdata;
          SEL_PBYTE: pbyte_q <= cfg_wdata[PBYTE_W-1:0];
          SEL_COUNT: cnt_q   <= cfg_wdata[CNT_W-1:0];
          SEL_CTRL: begin
            word_q <= cfg_wdata[1];
            down_q <= cfg_wdata[2];
            en_q   <= cfg_wdata[0] && (cnt_q != '0);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_req_queue.sv
module dma_req_queue #(
  parameter int DEPTH = 4,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SRC_W-1:0] push_src,
  input  logic             pop,
  input  logic             flush,
  output logic             empty,
  output logic [SRC_W-1:0] head_src
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = PTR_W + 1;

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [FILL_W-1:0] fill;
  logic [SRC_W-1:0]  slot [DEPTH];
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (fill == '0);
  assign do_push  = push && (fill != FILL_W'(DEPTH));
  assign do_pop   = pop && !empty;
  assign head_src = slot[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) begin
        for (int i = 0; i < DEPTH; i++)
          if (wr_ptr == PTR_W'(i)) slot[i] <= push_src;
        wr_ptr <= ptr_next(wr_ptr);
      end
      if (do_pop) rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + FILL_W'(1);
        2'b01:   fill <= fill - FILL_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_fixed_pkg::*;
#(
  parameter logic [SRC_W-1:0] RX_SRC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               q_empty,
  input  logic [SRC_W-1:0]   head_src,
  input  logic [ADDR_W-1:0]  mem_addr,
  input  logic [PBYTE_W-1:0] pbyte,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               pop,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic               step,
  output logic               finish,
  output logic               from_periph,
  output logic               done
);
  xfer_state_e         state_q, state_d;
  logic                dir_q;
  logic [DATA_W-1:0]   buf_q;
  logic                done_q;
  logic [ADDR_W-1:0]   p_addr;

  assign p_addr      = periph_full(pbyte);
  assign from_periph = dir_q;
  assign done        = done_q;

  always_comb begin
    state_d   = state_q;
    pop       = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    step      = 1'b0;
    finish    = 1'b0;
    case (state_q)
      XS_IDLE: begin
        if (en && !q_empty) begin
          pop     = 1'b1;
          state_d = XS_READ;
        end
      end
      XS_READ: begin
        bus_req  = 1'b1;
        bus_addr = dir_q ? p_addr : mem_addr;
        state_d  = XS_WRITE;
      end
      XS_WRITE: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = dir_q ? mem_addr : p_addr;
        bus_wdata = buf_q;
        step      = 1'b1;
        finish    = (cnt == CNT_W'(1));
        state_d   = XS_IDLE;
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      dir_q   <= 1'b0;
      buf_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (pop) dir_q <= (head_src == RX_SRC);
      if (state_q == XS_READ) buf_q <= bus_rdata;
    end
  end
endmodule

// File: rtl/dma_fixed_chan.sv
module dma_fixed_chan
  import dma_fixed_pkg::*;
#(
  parameter int PEND_DEPTH = 4,
  parameter logic [SRC_W-1:0] RX_SRC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  input  logic [SRC_W-1:0]   req_src,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_word,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               chan_on,
  output logic               done
);
  logic [ADDR_W-1:0]  mem_q;
  logic [PBYTE_W-1:0] pbyte_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               word_q, down_q, en_q;
  logic               xfer_step, xfer_finish, xfer_pop, xfer_from_periph;
  logic               q_empty;
  logic [SRC_W-1:0]   q_head;

  assign chan_on  = en_q;
  assign bus_word = word_q;

  dma_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .step     (xfer_step),
    .finish   (xfer_finish),
    .mem_q    (mem_q),
    .pbyte_q  (pbyte_q),
    .cnt_q    (cnt_q),
    .word_q   (word_q),
    .down_q   (down_q),
    .en_q     (en_q)
  );

  dma_req_queue #(.DEPTH(PEND_DEPTH), .SRC_W(SRC_W)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (req_valid && en_q),
    .push_src(req_src),
    .pop     (xfer_pop),
    .flush   (xfer_finish),
    .empty   (q_empty),
    .head_src(q_head)
  );

  dma_xfer_fsm #(.RX_SRC(RX_SRC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .q_empty    (q_empty),
    .head_src   (q_head),
    .mem_addr   (mem_q),
    .pbyte      (pbyte_q),
    .cnt        (cnt_q),
    .bus_rdata  (bus_rdata),
    .pop        (xfer_pop),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .step       (xfer_step),
    .finish     (xfer_finish),
    .from_periph(xfer_from_periph),
    .done       (done)
  );
endmodule

// File: rtl/dma_fixed_chan_chk.sv
module dma_fixed_chan_chk
  import dma_fixed_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               chan_on,
  input logic               done,
  input logic               bus_req,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               from_periph,
  input logic               step,
  input logic [ADDR_W-1:0]  mem,
  input logic [PBYTE_W-1:0] pbyte,
  input logic [CNT_W-1:0]   cnt
);
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_on && $past(chan_on) && !$past(step) |-> $stable(mem) && $stable(cnt));

  p_pbyte_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chan_on && $past(chan_on) |-> $stable(pbyte));

  p_periph_high_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_we != from_periph) |-> bus_addr[ADDR_W-1:PBYTE_W] == '1);

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |=> bus_req && bus_we);

  p_data_carried_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |=> bus_wdata == $past(bus_rdata));

  p_count_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) - CNT_W'(1));

  p_done_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chan_on);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on |-> !bus_req);
endmodule

bind dma_fixed_chan dma_fixed_chan_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_on    (chan_on),
  .done       (done),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .from_periph(xfer_from_periph),
  .step       (xfer_step),
  .mem        (mem_q),
  .pbyte      (pbyte_q),
  .cnt        (cnt_q)
);

// File: tb/test_dma_fixed_chan.sv
module test_dma_fixed_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_src = '0;
  logic        bus_req, bus_we, bus_word, chan_on, done;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_fixed_chan i_dma_fixed_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_src(req_src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_on(chan_on), .done(done)
  );

  // Row: {mem start, periph byte, units, word, down, source}
  localparam logic [39:0] VEC [4] = '{
    {24'h001000, 8'h34, 4'd3, 1'b0, 1'b0, 2'd0},
    {24'h000002, 8'hF0, 4'd3, 1'b1, 1'b1, 2'd1},
    {24'hFFFFFF, 8'h00, 4'd2, 1'b0, 1'b0, 2'd2},
    {24'h123456, 8'hAB, 4'd1, 1'b1, 1'b0, 2'd3}
  };

  function automatic logic [23:0] exp_step(input logic [23:0] m, input logic w, input logic d);
    int signed inc;
    inc = w ? 2 : 1;
    if (d) inc = -inc;
    return 24'(int'(m) + inc);
  endfunction

  function automatic logic [23:0] exp_periph(input logic [7:0] b);
    return 24'hFFFF00 | {16'h0, b};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [23:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [23:0] m, input logic [7:0] p, input logic [15:0] n,
                       input logic w, input logic d);
    cfg_write(2'd0, m);
    cfg_write(2'd1, {16'h0, p});
    cfg_write(2'd2, {8'h0, n});
    cfg_write(2'd3, {21'h0, d, w, 1'b1});
  endtask

  // One unit: request, read two edges later, write, then idle/done cycle.
  task automatic one_unit(input logic [1:0] src, input logic [23:0] m, input logic [7:0] p,
                          input logic w, input logic last, input logic [15:0] data);
    logic rx;
    rx = (src == 2'd0);
    bus_rdata = data;
    req_valid = 1'b1; req_src = src;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 read issued two edges after request", {31'h0, bus_req}, 32'h1);
    chk("R6 first cycle is read", {31'h0, bus_we}, 32'h0);
    chk("R5 read address", {8'h0, bus_addr}, {8'h0, rx ? exp_periph(p) : m});
    chk("R7 unit size on read", {31'h0, bus_word}, {31'h0, w});
    @(negedge clk);
    chk("R6 second cycle is write", {30'h0, bus_req, bus_we}, 32'h3);
    chk("R5 write address", {8'h0, bus_addr}, {8'h0, rx ? m : exp_periph(p)});
    chk("R6 write data equals read data", {16'h0, bus_wdata}, {16'h0, data});
    @(negedge clk);
    chk("R8 done pulse at last unit only", {31'h0, done}, {31'h0, last});
    chk("R8 channel off after last unit", {31'h0, chan_on}, {31'h0, !last});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset chan_on", {31'h0, chan_on}, 32'h0);
    chk("R1 reset bus_req", {31'h0, bus_req}, 32'h0);
    chk("R1 reset done", {31'h0, done}, 32'h0);

    // Table walk: each row is a full run.
    for (int r = 0; r < 4; r++) begin
      logic [23:0] m;
      logic [7:0]  p;
      logic [3:0]  n;
      logic        w, d;
      logic [1:0]  s;
      {m, p, n, w, d, s} = VEC[r];
      setup(m, p, {12'h0, n}, w, d);
      chk("R2 channel enabled by control write", {31'h0, chan_on}, 32'h1);
      for (int k = 0; k < int'(n); k++) begin
        one_unit(s, m, p, w, (k == int'(n) - 1), 16'(16'hC300 + r * 16 + k));
        m = exp_step(m, w, d);
      end
    end

    // R3: enable with zero count is refused.
    cfg_write(2'd2, 24'h0);
    cfg_write(2'd3, 24'h1);
    chk("R3 zero count keeps channel off", {31'h0, chan_on}, 32'h0);

    // R9: requests while off produce no bus cycle.
    begin
      logic seen;
      seen = 1'b0;
      req_valid = 1'b1; req_src = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (bus_req) seen = 1'b1;
      end
      chk("R9 request while disabled ignored", {31'h0, seen}, 32'h0);
    end

    // R2: writes while enabled have no effect.
    setup(24'h000200, 8'h5C, 16'd1, 1'b0, 1'b0);
    cfg_write(2'd0, 24'h999999);
    cfg_write(2'd1, 24'h000011);
    cfg_write(2'd2, 24'h000007);
    cfg_write(2'd3, 24'h000006);
    chk("R2 control write while on ignored", {31'h0, chan_on}, 32'h1);
    chk("R2 size unchanged while on", {31'h0, bus_word}, 32'h0);
    one_unit(2'd1, 24'h000200, 8'h5C, 1'b0, 1'b1, 16'h1234);

    // R10: three back-to-back requests with mixed sources.
    begin
      logic [1:0]  srcs [3];
      logic [23:0] rd_a [3];
      logic [23:0] wr_a [3];
      int nr, nw, nd;
      srcs[0] = 2'd0; srcs[1] = 2'd1; srcs[2] = 2'd0;
      nr = 0; nw = 0; nd = 0;
      setup(24'h000400, 8'h77, 16'd3, 1'b0, 1'b0);
      for (int i = 0; i < 14; i++) begin
        req_valid = (i < 3);
        req_src   = (i < 3) ? srcs[i] : 2'd0;
        @(negedge clk);
        if (bus_req && !bus_we && nr < 3) begin rd_a[nr] = bus_addr; nr++; end
        if (bus_req && bus_we && nw < 3) begin wr_a[nw] = bus_addr; nw++; end
        if (done) nd++;
      end
      req_valid = 1'b0;
      chk("R10 three queued units served", nr, 3);
      chk("R10 three writes", nw, 3);
      chk("R10 queued unit 0 read (rx)", {8'h0, rd_a[0]}, {8'h0, exp_periph(8'h77)});
      chk("R10 queued unit 0 write", {8'h0, wr_a[0]}, 32'h000400);
      chk("R10 queued unit 1 read (mem)", {8'h0, rd_a[1]}, 32'h000401);
      chk("R10 queued unit 1 write", {8'h0, wr_a[1]}, {8'h0, exp_periph(8'h77)});
      chk("R10 queued unit 2 read (rx)", {8'h0, rd_a[2]}, {8'h0, exp_periph(8'h77)});
      chk("R10 queued unit 2 write", {8'h0, wr_a[2]}, 32'h000402);
      chk("R8 single done pulse", nd, 1);
      chk("R8 channel off after run", {31'h0, chan_on}, 32'h0);
    end

    // R9: requests after completion are ignored.
    begin
      logic seen;
      seen = 1'b0;
      req_valid = 1'b1; req_src = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (bus_req) seen = 1'b1;
      end
      chk("R9 request after done ignored", {31'h0, seen}, 32'h0);
    end

    summary();
  end
endmodule